// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Flag Unit

This block is the purely combinational datapath of an 8-bit processor. It takes two byte operands, an operation code and four status inputs: the carry, the half carry, the with-carry mode bit and the compare-mode bit. It returns a result together with the new condition code, carry, half carry and overflow values. Each output flag has its own update enable, so the surrounding core writes back only the flags the operation defines. Instruction decode and register storage belong to the host core.

Operand `a` is the register side. It is the augend, the minuend, the left side of a compare, the value that is rotated, decimal-adjusted, complemented or tested, and the low factor of a multiply. Operand `b` is the memory, immediate or second-register side. The result is 16 bits wide. Only the multiply uses the upper byte; every other operation leaves it at zero.

The block has no clock and no state, so it has no states or transitions. Each operation is one decode arm that is selected in the same cycle as its inputs.

Top module: `alu8_core`

## Requirements
- R1: `cc` is 2'b00 for a zero value, 2'b01 for a nonzero value with bit 7 clear, and 2'b10 for bit 7 set. It never takes 2'b11. Operation codes are: pass `b` = 0, AND = 1, OR = 2, XOR = 3. The logic operations and pass write the result and the condition code, and touch no other flag.
- R2: Add (code 4) computes `a + b + (wc ? c_in : 0)`. It sets C to the carry out of bit 7, IDC to the carry from bit 3 into bit 4, and OVF to two's-complement overflow. All four flags and the result are written.
- R3: Subtract (code 5) computes `a + ~b + (wc ? c_in : 1)`. C, IDC and OVF come from that addition, so C=1 means no borrow. All four flags and the result are written.
- R4: Compare (code 6) sets `cc` to 01, 00 or 10 when `a` is greater than, equal to or less than `b`. The comparison is signed when `com`=0 and unsigned when `com`=1. The register write, C, IDC and OVF enables stay low.
- R5: Rotate right (code 7) with `wc`=1 puts the old C into bit 7 and old bit 0 into C, and loads IDC from old bit 6.
- R6: Rotate left (code 8) with `wc`=1 puts the old C into bit 0 and old bit 7 into C, and loads IDC from old bit 4.
- R7: With `wc`=0, both rotates are plain 8-bit rotates and leave the C and IDC enables low. The condition code is written in both modes.
- R8: Decimal adjust (code 9) adds A0h when C is clear and 0Ah when IDC is clear, modulo 256. It writes the result and no flag.
- R9: Multiply (code 12) writes the unsigned 16-bit product of `a` and `b`. `cc` comes from the full product: 00 when zero, 10 when bit 15 is set, 01 otherwise.
- R10: Test under mask (code 10) sets `cc` to 00 when every bit of `a` selected by a one in `b` is set, and to 10 otherwise. It writes no register.
- R11: Complement (code 11) writes `~a` and no flag.
- R12: Codes 13 to 15 raise no enable. Whenever `res_we` is low, `res` is zero. The result's upper byte is zero for every operation except multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| a | input | 8 | Register-side operand |
| b | input | 8 | Memory, immediate or mask operand |
| c_in | input | 1 | Current carry flag |
| idc_in | input | 1 | Current half-carry flag |
| wc | input | 1 | With-carry mode bit |
| com | input | 1 | Compare mode, 1 = unsigned |
| res | output | 16 | Result, upper byte used by multiply only |
| res_we | output | 1 | Result is to be written back |
| cc | output | 2 | New condition code |
| cc_we | output | 1 | Condition code update enable |
| c_out | output | 1 | New carry |
| c_we | output | 1 | Carry update enable |
| idc_out | output | 1 | New half carry |
| idc_we | output | 1 | Half-carry update enable |
| ovf_out | output | 1 | New overflow |
| ovf_we | output | 1 | Overflow update enable |

## Verification
An add or subtract can raise the carry out and the signed overflow in the same evaluation. It can also inject the incoming carry through the with-carry mode on top of both. The bench provokes this with operand pairs such as 80h+80h and 7Fh+01h, and with subtract pairs that borrow across the sign boundary, each taken under both values of `wc` and `c_in`. A behavioural model built on integer arithmetic predicts every field, and each cycle's outputs are compared with it.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW = 8;
    localparam int PW = 2 * DW;

    typedef enum logic [3:0] {
        OP_PASS = 4'd0,
        OP_AND  = 4'd1,
        OP_OR   = 4'd2,
        OP_XOR  = 4'd3,
        OP_ADD  = 4'd4,
        OP_SUB  = 4'd5,
        OP_CMP  = 4'd6,
        OP_ROR  = 4'd7,
        OP_ROL  = 4'd8,
        OP_DADJ = 4'd9,
        OP_TMSK = 4'd10,
        OP_INV  = 4'd11,
        OP_MUL  = 4'd12
    } alu_op_e;

    localparam logic [1:0] CC_ZERO = 2'b00;
    localparam logic [1:0] CC_POS  = 2'b01;
    localparam logic [1:0] CC_NEG  = 2'b10;

    function automatic logic [1:0] cc_of_byte(input logic [DW-1:0] v);
        if (v == '0)          return CC_ZERO;
        else if (v[DW-1])     return CC_NEG;
        else                  return CC_POS;
    endfunction

    function automatic logic [1:0] cc_of_word(input logic [PW-1:0] v);
        if (v == '0)          return CC_ZERO;
        else if (v[PW-1])     return CC_NEG;
        else                  return CC_POS;
    endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    input  logic          wc,
    input  logic          c_in,
    output logic [DW-1:0] sum,
    output logic          carry,
    output logic          half,
    output logic          ovf
);
    localparam int HB = DW / 2;

    logic [DW-1:0] nb;
    logic          cin;
    logic [HB:0]   low_sum;
    logic [DW:0]   full_sum;

    always_comb begin
        nb       = sub ? ~b : b;
        cin      = wc ? c_in : sub;
        low_sum  = {1'b0, a[HB-1:0]} + {1'b0, nb[HB-1:0]} + {{HB{1'b0}}, cin};
        full_sum = {1'b0, a} + {1'b0, nb} + {{DW{1'b0}}, cin};
        sum      = full_sum[DW-1:0];
        carry    = full_sum[DW];
        half     = low_sum[HB];
        ovf      = (a[DW-1] == nb[DW-1]) && (sum[DW-1] != a[DW-1]);
    end

    always_comb begin
        if (sub && !wc && b == '0)
            p_sub_noborrow_r3: assert (carry && sum == a);
        if (!sub && !wc && b == '0)
            p_add_ident_r2: assert (!carry && !ovf && sum == a);
    end
endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic          left,
    input  logic          wc,
    input  logic          c_in,
    output logic [DW-1:0] y,
    output logic          c_o,
    output logic          idc_o
);
    always_comb begin
        if (left) begin
            y     = {a[DW-2:0], (wc ? c_in : a[DW-1])};
            c_o   = a[DW-1];
            idc_o = a[DW/2];
        end else begin
            y     = {(wc ? c_in : a[0]), a[DW-1:1]};
            c_o   = a[0];
            idc_o = a[DW-2];
        end
    end

    always_comb begin
        if (!wc)
            p_rot_ones_r7: assert ($countones(y) == $countones(a));
    end
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
    parameter int DW = 8
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [2*DW-1:0] p
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] part [DW];

    for (genvar i = 0; i < DW; i++) begin : g_part
        assign part[i] = b[i] ? ({{DW{1'b0}}, a} << i) : '0;
    end

    always_comb begin
        p = '0;
        for (int i = 0; i < DW; i++) p = p + part[i];
    end

    always_comb begin
        if (b == {{(DW-1){1'b0}}, 1'b1})
            p_mul_unit_r9: assert (p == {{DW{1'b0}}, a});
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          c_in,
    input  logic          idc_in,
    input  logic          wc,
    input  logic          com,
    output logic [PW-1:0] res,
    output logic          res_we,
    output logic [1:0]    cc,
    output logic          cc_we,
    output logic          c_out,
    output logic          c_we,
    output logic          idc_out,
    output logic          idc_we,
    output logic          ovf_out,
    output logic          ovf_we
);
    alu_op_e       op_e;
    logic [DW-1:0] as_sum, rot_y;
    logic          as_c, as_h, as_v, rot_c, rot_h;
    logic [PW-1:0] prod;
    logic [DW-1:0] key_a, key_b, dadj;
    logic [DW-1:0] byte_r;

    assign op_e = alu_op_e'(op);

    alu8_addsub #(.DW(DW)) u_addsub (
        .a(a), .b(b), .sub(op_e == OP_SUB), .wc(wc), .c_in(c_in),
        .sum(as_sum), .carry(as_c), .half(as_h), .ovf(as_v)
    );

    alu8_rotate #(.DW(DW)) u_rotate (
        .a(a), .left(op_e == OP_ROL), .wc(wc), .c_in(c_in),
        .y(rot_y), .c_o(rot_c), .idc_o(rot_h)
    );

    alu8_mul #(.DW(DW)) u_mul (
        .a(a), .b(b), .p(prod)
    );

    always_comb begin
        key_a = {a[DW-1] ^ ~com, a[DW-2:0]};
        key_b = {b[DW-1] ^ ~com, b[DW-2:0]};
        dadj  = a + (c_in ? 8'h00 : 8'hA0) + (idc_in ? 8'h00 : 8'h0A);
    end

    always_comb begin
        byte_r  = '0;
        res     = '0;
        res_we  = 1'b0;
        cc      = CC_ZERO;
        cc_we   = 1'b0;
        c_out   = c_in;
        c_we    = 1'b0;
        idc_out = idc_in;
        idc_we  = 1'b0;
        ovf_out = 1'b0;
        ovf_we  = 1'b0;
        unique case (op_e)
            OP_PASS, OP_AND, OP_OR, OP_XOR: begin
                case (op_e)
                    OP_AND:  byte_r = a & b;
                    OP_OR:   byte_r = a | b;
                    OP_XOR:  byte_r = a ^ b;
                    default: byte_r = b;
                endcase
                res    = {{DW{1'b0}}, byte_r};
                res_we = 1'b1;
                cc     = cc_of_byte(byte_r);
                cc_we  = 1'b1;
            end
            OP_ADD, OP_SUB: begin
                res     = {{DW{1'b0}}, as_sum};
                res_we  = 1'b1;
                cc      = cc_of_byte(as_sum);
                cc_we   = 1'b1;
                c_out   = as_c;
                c_we    = 1'b1;
                idc_out = as_h;
                idc_we  = 1'b1;
                ovf_out = as_v;
                ovf_we  = 1'b1;
            end
            OP_CMP: begin
                cc    = (key_a > key_b) ? CC_POS : (key_a == key_b) ? CC_ZERO : CC_NEG;
                cc_we = 1'b1;
            end
            OP_ROR, OP_ROL: begin
                res     = {{DW{1'b0}}, rot_y};
                res_we  = 1'b1;
                cc      = cc_of_byte(rot_y);
                cc_we   = 1'b1;
                c_out   = wc ? rot_c : c_in;
                c_we    = wc;
                idc_out = wc ? rot_h : idc_in;
                idc_we  = wc;
            end
            OP_DADJ: begin
                res    = {{DW{1'b0}}, dadj};
                res_we = 1'b1;
            end
            OP_TMSK: begin
                cc    = ((a & b) == b) ? CC_ZERO : CC_NEG;
                cc_we = 1'b1;
            end
            OP_INV: begin
                res    = {{DW{1'b0}}, ~a};
                res_we = 1'b1;
            end
            OP_MUL: begin
                res    = prod;
                res_we = 1'b1;
                cc     = cc_of_word(prod);
                cc_we  = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        p_cc_legal_r1: assert (cc != 2'b11);
        if (op_e == OP_CMP)
            p_cmp_nowrite_r4: assert (!res_we && !c_we && !idc_we && !ovf_we);
        if (op_e == OP_DADJ)
            p_dadj_quiet_r8: assert (!cc_we && !c_we && !idc_we && !ovf_we);
        if (op_e == OP_INV)
            p_inv_quiet_r11: assert (!cc_we && !c_we && !idc_we && !ovf_we);
        if (op_e != OP_MUL)
            p_hi_zero_r12: assert (res[PW-1:DW] == '0);
    end
endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [3:0]  op;
    logic [7:0]  a, b;
    logic        c_in, idc_in, wc, com;
    logic [15:0] res;
    logic        res_we, cc_we, c_out, c_we, idc_out, idc_we, ovf_out, ovf_we;
    logic [1:0]  cc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    alu8_core u_alu8_core (
        .op(op), .a(a), .b(b), .c_in(c_in), .idc_in(idc_in), .wc(wc), .com(com),
        .res(res), .res_we(res_we), .cc(cc), .cc_we(cc_we),
        .c_out(c_out), .c_we(c_we), .idc_out(idc_out), .idc_we(idc_we),
        .ovf_out(ovf_out), .ovf_we(ovf_we)
    );

    function automatic logic [1:0] code_of(input int v, input int bits);
        if (v == 0) return 2'b00;
        if (v >= (1 << (bits - 1))) return 2'b10;
        return 2'b01;
    endfunction

    function automatic string tag_of(input int o, input bit w);
        case (o)
            0, 1, 2, 3: return "R1";
            4: return "R2";
            5: return "R3";
            6: return "R4";
            7: return w ? "R5" : "R7";
            8: return w ? "R6" : "R7";
            9: return "R8";
            10: return "R10";
            11: return "R11";
            12: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic apply(input int o, input int va, input int vb,
                         input bit ci, input bit hi, input bit w, input bit cm);
        int e_res = 0, s, sa, sb, cin, nb, sga, sgn;
        bit e_rwe = 0, e_ccwe = 0, e_cwe = 0, e_hwe = 0, e_vwe = 0;
        bit e_c = 0, e_h = 0, e_v = 0;
        logic [1:0] e_cc = 2'b00;
        bit bad;
        @(posedge clk);
        #1;
        op = 4'(o); a = 8'(va); b = 8'(vb); c_in = ci; idc_in = hi; wc = w; com = cm;
        case (o)
            0, 1, 2, 3: begin
                e_res = (o == 0) ? vb : (o == 1) ? (va & vb) : (o == 2) ? (va | vb) : (va ^ vb);
                e_rwe = 1; e_ccwe = 1; e_cc = code_of(e_res, 8);
            end
            4, 5: begin
                nb  = (o == 5) ? 255 - vb : vb;
                cin = w ? int'(ci) : ((o == 5) ? 1 : 0);
                s   = va + nb + cin;
                e_res = s % 256; e_rwe = 1; e_ccwe = 1; e_cc = code_of(e_res, 8);
                e_c = (s > 255); e_cwe = 1;
                e_h = ((va % 16) + (nb % 16) + cin) > 15; e_hwe = 1;
                sga = (va > 127) ? va - 256 : va;
                sgn = (nb > 127) ? nb - 256 : nb;
                e_v = (sga + sgn + cin > 127) || (sga + sgn + cin < -128); e_vwe = 1;
            end
            6: begin
                sa = cm ? va : ((va > 127) ? va - 256 : va);
                sb = cm ? vb : ((vb > 127) ? vb - 256 : vb);
                e_ccwe = 1; e_cc = (sa > sb) ? 2'b01 : (sa == sb) ? 2'b00 : 2'b10;
            end
            7: begin
                e_res = (va / 2) + ((w ? int'(ci) : va % 2) * 128);
                e_rwe = 1; e_ccwe = 1; e_cc = code_of(e_res, 8);
                if (w) begin e_cwe = 1; e_c = va % 2; e_hwe = 1; e_h = (va / 64) % 2; end
            end
            8: begin
                e_res = ((va * 2) % 256) + (w ? int'(ci) : va / 128);
                e_rwe = 1; e_ccwe = 1; e_cc = code_of(e_res, 8);
                if (w) begin e_cwe = 1; e_c = va / 128; e_hwe = 1; e_h = (va / 16) % 2; end
            end
            9: begin
                e_res = (va + (ci ? 0 : 160) + (hi ? 0 : 10)) % 256; e_rwe = 1;
            end
            10: begin
                e_ccwe = 1; e_cc = ((va & vb) == vb) ? 2'b00 : 2'b10;
            end
            11: begin
                e_res = 255 - va; e_rwe = 1;
            end
            12: begin
                e_res = va * vb; e_rwe = 1; e_ccwe = 1; e_cc = code_of(e_res, 16);
            end
            default: ;
        endcase
        @(negedge clk);
        bad = (res != 16'(e_res)) || (res_we != e_rwe) || (cc_we != e_ccwe) ||
              (c_we != e_cwe) || (idc_we != e_hwe) || (ovf_we != e_vwe) ||
              (e_ccwe && cc != e_cc) || (e_cwe && c_out != e_c) ||
              (e_hwe && idc_out != e_h) || (e_vwe && ovf_out != e_v);
        checks++;
        if (bad) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h c=%b h=%b wc=%b com=%b: actual res=%h we=%b cc=%b/%b c=%b/%b h=%b/%b v=%b/%b expected res=%h we=%b cc=%b/%b c=%b/%b h=%b/%b v=%b/%b",
                     tag_of(o, w), o, va, vb, ci, hi, w, cm,
                     res, res_we, cc, cc_we, c_out, c_we, idc_out, idc_we, ovf_out, ovf_we,
                     16'(e_res), e_rwe, e_cc, e_ccwe, e_c, e_cwe, e_h, e_hwe, e_v, e_vwe);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        op = 4'd15; a = 0; b = 0; c_in = 0; idc_in = 0; wc = 0; com = 0;
        // R12: idle code raises no enable
        apply(15, 8'h5A, 8'hA5, 1, 1, 1, 1);
        apply(13, 8'hFF, 8'hFF, 0, 0, 0, 0);
        // R1: codes and logic ops
        apply(0, 8'h00, 8'h00, 0, 0, 0, 0);
        apply(0, 8'h00, 8'h80, 0, 0, 0, 0);
        apply(1, 8'hF0, 8'h3C, 0, 0, 0, 0);
        apply(2, 8'h01, 8'h02, 0, 0, 0, 0);
        apply(3, 8'hAA, 8'hAA, 0, 0, 0, 0);
        // R2: carry and overflow together, with-carry injection
        for (int w = 0; w < 2; w++)
            for (int c = 0; c < 2; c++) begin
                apply(4, 8'h80, 8'h80, c[0], 0, w[0], 0);
                apply(4, 8'h7F, 8'h01, c[0], 0, w[0], 0);
                apply(4, 8'hFF, 8'h00, c[0], 0, w[0], 0);
                apply(4, 8'h0F, 8'h01, c[0], 0, w[0], 0);
                // R3: borrow across sign boundary
                apply(5, 8'h80, 8'h01, c[0], 0, w[0], 0);
                apply(5, 8'h00, 8'h01, c[0], 0, w[0], 0);
                apply(5, 8'h10, 8'h10, c[0], 0, w[0], 0);
                apply(5, 8'h7F, 8'hFF, c[0], 0, w[0], 0);
            end
        // R4: signed vs unsigned compare
        apply(6, 8'h80, 8'h01, 0, 0, 0, 0);
        apply(6, 8'h80, 8'h01, 0, 0, 0, 1);
        apply(6, 8'h42, 8'h42, 1, 1, 1, 1);
        // R5, R6, R7: rotates
        apply(7, 8'h41, 8'h00, 0, 0, 1, 0);
        apply(7, 8'h01, 8'h00, 1, 0, 0, 0);
        apply(8, 8'h90, 8'h00, 1, 0, 1, 0);
        apply(8, 8'h80, 8'h00, 0, 1, 0, 0);
        // R8: decimal adjust
        for (int k = 0; k < 4; k++) apply(9, 8'h7B, 8'h00, k[0], k[1], 0, 0);
        // R9: multiply
        apply(12, 8'hFF, 8'hFF, 0, 0, 0, 0);
        apply(12, 8'h10, 8'h10, 0, 0, 0, 0);
        apply(12, 8'h00, 8'h37, 0, 0, 0, 0);
        // R10: test under mask
        apply(10, 8'hF3, 8'h03, 0, 0, 0, 0);
        apply(10, 8'hF1, 8'h03, 0, 0, 0, 0);
        apply(10, 8'h00, 8'h00, 0, 0, 0, 0);
        // R11: complement
        apply(11, 8'h5A, 8'h00, 1, 1, 1, 0);
        for (int i = 0; i < 4000; i++)
            apply($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule